// File: doc/BRIEF.md
# PCI Configuration Window Translator

This block sits on a CPU-side request bus and claims the accesses that fall into a 4 MiB memory-mapped configuration window. Each claimed access becomes one PCI configuration read or write request on a separate channel. That channel carries a combined configuration address, the write data, the byte size and the direction.

The target device is not given as a binary number. It is selected by a one-hot style field in the address. The block scans that field upward and takes the position of the lowest set bit as the device number. It places that number above an 11-bit register offset to form the configuration address. Data is little-endian and sits in the low byte lanes. Read data coming back is trimmed to the access size before it returns to the CPU.

Accesses outside the window, and accesses with an unsupported size code, are not claimed. The block raises a miss indication so that another decoder can answer. Only one request is in flight at a time. The CPU sees ready only once the configuration side has reported completion.

Top module: `cfgwin_xlate`

## Requirements
- R1: While reset is applied, and until the first request arrives after reset, `cfg_req`, `cpu_ready` and `cpu_miss` are all low.
- R2: A request is claimed only if `cpu_addr` lies in the range 0x8080_0000 to 0x80BF_FFFF. A request outside that range raises `cpu_miss` in the same cycle and never produces `cfg_req`.
- R3: Bits 10:0 of the window offset appear unchanged on `cfg_addr[10:0]`.
- R4: The device number is the index, counted from zero, of the lowest set bit among window-offset bits 11 to 21. Bit 11 gives device 0 and bit 21 gives device 10. The device number is carried on `cfg_addr[14:11]`, so `cfg_addr` = device × 2048 + offset.
- R5: When none of offset bits 11 to 21 is set, the device number is 11.
- R6: When several select bits are set, only the lowest one decides the device number, and the higher ones have no effect on `cfg_addr`.
- R7: Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. The size code, the direction and the write data are passed to the configuration channel unchanged. On a read, the bytes of `cpu_rdata` above the access size are zero, and the low bytes come from `cfg_rdata[7:0]` upward.
- R8: A claimed request raises `cfg_req` one cycle after acceptance. `cfg_req` stays high with `cpu_ready` low until a cycle in which `cfg_done` is high. In the cycle after that, `cpu_ready` is high for exactly one cycle and `cfg_req` is low.
- R9: Size code 3 is not claimed, even inside the window. It raises `cpu_miss` and never produces `cfg_req`.
- R10: While `cfg_req` is high, `cfg_addr`, `cfg_write`, `cfg_size` and `cfg_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | CPU request present, held until ready or miss |
| cpu_ready | output | 1 | One-cycle completion of a claimed request |
| cpu_addr | input | 32 | CPU byte address |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_wdata | input | 32 | Write data, little-endian in low lanes |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_miss | output | 1 | Request not claimed by this block |
| cfg_req | output | 1 | Configuration request outstanding |
| cfg_addr | output | 15 | Device number in 14:11, register offset in 10:0 |
| cfg_write | output | 1 | Configuration direction |
| cfg_size | output | 2 | Configuration size code |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_done | input | 1 | Configuration side completes the request |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_done |

## Verification
Completion and fresh decoding can fall in the same short span. A configuration side that answers in the very first cycle of `cfg_req` makes the ready pulse follow acceptance by only two cycles. The bench provokes this with zero-wait completion followed at once by an out-of-window request. It judges by whether `cpu_ready` pulses once with the right data, and whether the next request is seen as a miss with no stale `cfg_req`. Long-wait completions are also checked, with the address held stable and ready held low throughout.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  // Access size codes carried unchanged from CPU to configuration side
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } cfgwin_state_e;

endpackage

// File: rtl/cfgwin_rst_sync.sv
module cfgwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode #(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_BITS = 22,
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int          REG_BITS = 11,
  parameter int          SEL_BITS = 11,
  parameter int          DEV_W    = $clog2(SEL_BITS + 1),
  parameter int          CFG_AW   = REG_BITS + DEV_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              claim_ok,
  output logic [CFG_AW-1:0] cfg_addr_d
);

  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_BITS];

  logic                win_hit;
  logic                size_ok;
  logic [SEL_BITS-1:0] sel_field;
  logic [SEL_BITS-1:0] lowest;
  logic [SEL_BITS:0]   seen_below;
  logic [DEV_W-1:0]    dev_num;
  logic [REG_BITS-1:0] reg_off;

  assign win_hit   = (addr[ADDR_W-1:WIN_BITS] == WIN_TAG);
  assign size_ok   = (size != 2'd3);
  assign claim_ok  = win_hit && size_ok;
  assign reg_off   = addr[REG_BITS-1:0];
  assign sel_field = addr[REG_BITS +: SEL_BITS];

  // Priority chain: a select bit counts only when no lower bit is set
  assign seen_below[0] = 1'b0;
  for (genvar g = 0; g < SEL_BITS; g++) begin : g_scan
    assign lowest[g]       = sel_field[g] && !seen_below[g];
    assign seen_below[g+1] = seen_below[g] || sel_field[g];
  end

  always_comb begin
    dev_num = DEV_W'(SEL_BITS);
    for (int i = 0; i < SEL_BITS; i++) begin
      if (lowest[i]) begin
        dev_num = DEV_W'(i);
      end
    end
  end

  assign cfg_addr_d = {dev_num, reg_off};

  // Checks on the scan (R4, R6)
  always_comb begin
    assert_dev_range_R4: assert (dev_num <= DEV_W'(SEL_BITS));
    assert_single_select_R6: assert ($onehot0(lowest));
  end

endmodule

// File: rtl/cfgwin_lane.sv
module cfgwin_lane #(
  parameter int DATA_W = 32,
  parameter int NBYTES = DATA_W / 8
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] raw_rdata,
  output logic [DATA_W-1:0] trim_rdata
);

  // Little-endian: an access of 2**size bytes occupies lanes 0 upward
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic keep;
    assign keep = (b < (1 << size));
    assign trim_rdata[b*8 +: 8] = keep ? raw_rdata[b*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int CFG_AW = 15,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic [CFG_AW-1:0] addr_d,
  input  logic              write_d,
  input  logic [1:0]        size_d,
  input  logic [DATA_W-1:0] wdata_d,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata_d,
  output logic              idle,
  output logic              busy,
  output logic              resp,
  output logic [CFG_AW-1:0] addr_q,
  output logic              write_q,
  output logic [1:0]        size_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  cfgwin_state_e state_q, state_d;
  logic          load_req;
  logic          load_rsp;

  assign load_req = (state_q == ST_IDLE) && claim;
  assign load_rsp = (state_q == ST_BUSY) && done;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (claim) state_d = ST_BUSY;
      ST_BUSY: if (done)  state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Request holding registers, loaded only on acceptance
  always_ff @(posedge clk) begin
    if (load_req) begin
      addr_q  <= addr_d;
      write_q <= write_d;
      size_q  <= size_d;
      wdata_q <= wdata_d;
    end
  end

  // Response register, loaded only on completion
  always_ff @(posedge clk) begin
    if (load_rsp) begin
      rdata_q <= rdata_d;
    end
  end

  assign idle = (state_q == ST_IDLE);
  assign busy = (state_q == ST_BUSY);
  assign resp = (state_q == ST_RESP);

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && !resp));

  assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp |=> !resp);

  assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp) |-> $past(busy && done));

  assert_fields_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(addr_q) && $stable(write_q) &&
                         $stable(size_q) && $stable(wdata_q)));

endmodule

// File: rtl/cfgwin_xlate.sv
module cfgwin_xlate
  import cfgwin_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          WIN_BITS = 22,
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int          REG_BITS = 11,
  parameter int          SEL_BITS = 11,
  localparam int         DEV_W    = $clog2(SEL_BITS + 1),
  localparam int         CFG_AW   = REG_BITS + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_write,
  input  logic [1:0]        cpu_size,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_miss,
  output logic              cfg_req,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic              cfg_write,
  output logic [1:0]        cfg_size,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_done,
  input  logic [DATA_W-1:0] cfg_rdata
);

  logic              rst_sync_n;
  logic              claim_ok;
  logic [CFG_AW-1:0] cfg_addr_d;
  logic [DATA_W-1:0] trim_rdata;
  logic              idle;

  cfgwin_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfgwin_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .WIN_BASE (WIN_BASE),
    .REG_BITS (REG_BITS),
    .SEL_BITS (SEL_BITS),
    .DEV_W    (DEV_W),
    .CFG_AW   (CFG_AW)
  ) u_dec (
    .addr       (cpu_addr),
    .size       (cpu_size),
    .claim_ok   (claim_ok),
    .cfg_addr_d (cfg_addr_d)
  );

  cfgwin_lane #(
    .DATA_W (DATA_W)
  ) u_lane (
    .size       (cfg_size),
    .raw_rdata  (cfg_rdata),
    .trim_rdata (trim_rdata)
  );

  cfgwin_ctrl #(
    .CFG_AW (CFG_AW),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .claim   (cpu_valid && claim_ok),
    .addr_d  (cfg_addr_d),
    .write_d (cpu_write),
    .size_d  (cpu_size),
    .wdata_d (cpu_wdata),
    .done    (cfg_done),
    .rdata_d (trim_rdata),
    .idle    (idle),
    .busy    (cfg_req),
    .resp    (cpu_ready),
    .addr_q  (cfg_addr),
    .write_q (cfg_write),
    .size_q  (cfg_size),
    .wdata_q (cfg_wdata),
    .rdata_q (cpu_rdata)
  );

  assign cpu_miss = cpu_valid && !claim_ok && idle && rst_sync_n;

  assert_miss_unclaimed_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_miss |=> !cfg_req);

  assert_byte_trim_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_ready && !cfg_write && cfg_size == SZ_BYTE) |-> (cpu_rdata[DATA_W-1:8] == '0));

endmodule

// File: tb/cfgwin_xlate_tb_top.sv
module cfgwin_xlate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;

  logic        clk;
  logic        rst_n;
  logic        cpu_valid;
  logic        cpu_ready;
  logic [31:0] cpu_addr;
  logic        cpu_write;
  logic [1:0]  cpu_size;
  logic [31:0] cpu_wdata;
  logic [31:0] cpu_rdata;
  logic        cpu_miss;
  logic        cfg_req;
  logic [14:0] cfg_addr;
  logic        cfg_write;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_wdata;
  logic        cfg_done;
  logic [31:0] cfg_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  cfgwin_xlate dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_ready (cpu_ready),
    .cpu_addr  (cpu_addr),
    .cpu_write (cpu_write),
    .cpu_size  (cpu_size),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_miss  (cpu_miss),
    .cfg_req   (cfg_req),
    .cfg_addr  (cfg_addr),
    .cfg_write (cfg_write),
    .cfg_size  (cfg_size),
    .cfg_wdata (cfg_wdata),
    .cfg_done  (cfg_done),
    .cfg_rdata (cfg_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", WDOG_LIMIT, 0);
    summary();
    $finish;
  end

  // R1: outputs quiet in and just after reset
  task automatic t_reset();
    rst_n = 1'b0;
    cpu_valid = 1'b0; cpu_addr = '0; cpu_write = 1'b0; cpu_size = 2'd2;
    cpu_wdata = '0; cfg_done = 1'b0; cfg_rdata = '0;
    repeat (3) @(negedge clk);
    check(!cfg_req && !cpu_ready && !cpu_miss, "R1 in reset",
          {29'd0, cfg_req, cpu_ready, cpu_miss}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!cfg_req && !cpu_ready && !cpu_miss, "R1 after reset",
          {29'd0, cfg_req, cpu_ready, cpu_miss}, 32'd0);
  endtask

  // One claimed access, completed after wait_cyc extra cycles
  task automatic t_access(input logic [31:0] addr, input logic wr,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input logic [14:0] exp_cfg, input int wait_cyc,
                          input logic [31:0] rsp, input logic [31:0] exp_rd,
                          input string tag);
    bit held_ok;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = addr; cpu_write = wr; cpu_size = sz; cpu_wdata = wd;
    #1;
    check(!cpu_miss, {tag, " R2 no miss"}, {31'd0, cpu_miss}, 32'd0);
    @(negedge clk);
    check(cfg_req && !cpu_ready, {tag, " R8 req raised"},
          {30'd0, cfg_req, cpu_ready}, 32'd2);
    check(cfg_addr == exp_cfg, {tag, " R3 R4 cfg_addr"}, {17'd0, cfg_addr}, {17'd0, exp_cfg});
    check(cfg_write == wr && cfg_size == sz, {tag, " R7 dir/size"},
          {29'd0, cfg_write, cfg_size}, {29'd0, wr, sz});
    if (wr) check(cfg_wdata == wd, {tag, " R7 wdata"}, cfg_wdata, wd);
    held_ok = 1'b1;
    for (int i = 0; i < wait_cyc; i++) begin
      @(negedge clk);
      if (!cfg_req || cpu_ready || cfg_addr != exp_cfg || cfg_size != sz) held_ok = 1'b0;
    end
    if (wait_cyc > 0)
      check(held_ok, {tag, " R10 R8 held while waiting"}, {31'd0, held_ok}, 32'd1);
    cfg_done = 1'b1; cfg_rdata = rsp;
    @(negedge clk);
    cfg_done = 1'b0; cfg_rdata = 32'h5A5A_5A5A;
    check(cpu_ready && !cfg_req, {tag, " R8 ready pulse"},
          {30'd0, cpu_ready, cfg_req}, 32'd2);
    if (!wr) check(cpu_rdata == exp_rd, {tag, " R7 rdata"}, cpu_rdata, exp_rd);
    cpu_valid = 1'b0;
    @(negedge clk);
    check(!cpu_ready && !cfg_req, {tag, " R8 single pulse"},
          {30'd0, cpu_ready, cfg_req}, 32'd0);
  endtask

  // Unclaimed request: miss now, no configuration request afterwards
  task automatic t_miss(input logic [31:0] addr, input logic [1:0] sz, input string tag);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = addr; cpu_write = 1'b0; cpu_size = sz;
    #1;
    check(cpu_miss, {tag, " miss raised"}, {31'd0, cpu_miss}, 32'd1);
    @(negedge clk);
    check(!cfg_req && !cpu_ready, {tag, " not claimed"},
          {30'd0, cfg_req, cpu_ready}, 32'd0);
    cpu_valid = 1'b0;
    #1;
    check(!cpu_miss, {tag, " miss drops"}, {31'd0, cpu_miss}, 32'd0);
  endtask

  initial begin
    t_reset();
    // R3 R4: bit 11 selects device 0
    t_access(32'h8080_081C, 1'b0, 2'd2, 32'h0, 15'h001C, 1, 32'h1122_3344, 32'h1122_3344, "R4 dev0");
    // R4 R7: bit 16 selects device 5, halfword write
    t_access(32'h8081_0204, 1'b1, 2'd1, 32'hA5A5_1234, 15'h2A04, 2, 32'h0, 32'h0, "R4 dev5 write");
    // R5: no select bit, device 11
    t_access(32'h8080_07FF, 1'b0, 2'd2, 32'h0, 15'h5FFF, 0, 32'hCAFE_F00D, 32'hCAFE_F00D, "R5 none");
    // R6: bits 13 and 19 set, lowest wins
    t_access(32'h8088_2010, 1'b1, 2'd2, 32'h0BAD_C0DE, 15'h1010, 1, 32'h0, 32'h0, "R6 multi");
    // R4 R7 R10: bit 21 device 10, byte read trimmed, long wait
    t_access(32'h80A0_0003, 1'b0, 2'd0, 32'h0, 15'h5003, 5, 32'hDEAD_BEEF, 32'h0000_00EF, "R7 byte");
    // R6 R7 R2: top of window, lowest set is bit 12, halfword read
    t_access(32'h80BF_F002, 1'b0, 2'd1, 32'h0, 15'h0802, 1, 32'hDEAD_BEEF, 32'h0000_BEEF, "R7 half");
    // R2: edges just outside the window
    t_miss(32'h807F_FFFC, 2'd2, "R2 below");
    t_miss(32'h80C0_0000, 2'd2, "R2 above");
    // R9: unsupported size code in window
    t_miss(32'h8080_0800, 2'd3, "R9 size3");
    // Same-cycle corner: zero-wait completion then immediate miss
    t_access(32'h8084_0000, 1'b0, 2'd2, 32'h0, 15'h3800, 0, 32'h0102_0304, 32'h0102_0304, "R8 fast");
    t_miss(32'h0000_0CF8, 2'd2, "R2 after fast");
    summary();
    $finish;
  end

endmodule